// File: doc/BRIEF.md
# Sequential DRAM Stream Master

This block sits on the client side of a simple word-wide DRAM access controller and turns that controller into a tape-like store for a stream of samples. In record mode it takes samples from an upstream valid/ready port and writes them to consecutive memory words from address zero. In play mode it reads the same words back in order, delivers each one on a sample-out port, and loops to the start after the last recorded word.

The memory side follows a handshake in which the controller may drop a command without notice to run a refresh. The master issues exactly one word access at a time and checks for a command acknowledge on the cycle after each issue. When the acknowledge does not come, it reissues the same command (same address, same data) as soon as the controller reports ready again. A change of direction ends the current sequence: the read/write select changes first, enable stays low for at least one clock after that, and the address counter restarts at zero. The length of a recording is held when recording stops, and that held length sets the wrap point for playback.

Top module: `sdm_stream_master`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mem_en` is 0, `mem_rd` is 1 (read selected), `out_valid` is 0, `in_ready` is 0 and `mem_addr` is 0.
- R2: `mem_en` rises only after a clock edge at which `mem_ready` was sampled high, and each issue lasts exactly one cycle.
- R3: `mem_rd` is 1 for a read and 0 for a write. It holds its value through a stream, and it never changes in the cycle just before `mem_en` rises.
- R4: When `mem_ack` is not high on the cycle after an issue, the same command is reissued with the same address and write data once `mem_ready` is high again.
- R5: For an acknowledged read, `mem_rdata` is captured on the first edge at which `mem_ready` is back high. It appears on `out_data` with a single-cycle `out_valid` pulse one cycle later.
- R6: The first write of a recording and the first read of a playback use address 0. The address advances by one after every acknowledged access that completes.
- R7: During playback, the read after the one at address (length-1) goes to address 0.
- R8: While nothing has been recorded since reset, `play_req` has no effect: no memory command is issued and `out_valid` stays low.
- R9: The recording length is stored when `rec_req` falls. A recording that wrote no word keeps the previous length and data for playback.
- R10: `in_ready` is high only in record mode while no access is in flight and `mem_ready` is high. Each sample taken with `in_valid` and `in_ready` is written to memory exactly once, in arrival order.
- R11: `rec_req` takes priority over `play_req` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req | input | 1 | Record mode request (level) |
| play_req | input | 1 | Playback mode request (level) |
| in_valid | input | 1 | Upstream sample valid |
| in_data | input | DW | Upstream sample |
| in_ready | output | 1 | Block accepts the offered sample this cycle |
| out_valid | output | 1 | Single-cycle pulse: a played-back sample is on out_data |
| out_data | output | DW | Played-back sample |
| mem_en | output | 1 | Command strobe to the memory controller |
| mem_rd | output | 1 | Direction select: 1 read, 0 write |
| mem_addr | output | AW | Word address of the command |
| mem_wdata | output | DW | Write data of the command |
| mem_ready | input | 1 | Controller idle and able to take a command |
| mem_ack | input | 1 | Command taken (high the cycle after a taken command) |
| mem_rdata | input | DW | Read data, valid when ready returns after a read |

## Verification
Recording is tried with back-to-back samples and with samples spaced by idle cycles. The second pattern separates a design that waits for `in_valid` from one that writes stale data. Playback runs long enough to wrap several times, so a wrong length compare or an off-by-one wrap shows up in the address sequence. Refreshes are injected exactly on an issue cycle in both directions, which separates true retry from silently skipping or advancing the address. A play request before any recording, and a recording that captures no words, check that the held length and the gating come from real recorded data.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [2:0] {
    AF_IDLE,
    AF_TURN,
    AF_ISSUE,
    AF_CHECK,
    AF_WAIT,
    AF_RETRY
  } acc_state_t;

  typedef enum logic [1:0] {
    MD_NONE,
    MD_REC,
    MD_PLAY
  } mode_t;

endpackage

// File: rtl/sdm_access_fsm.sv
// One-word-at-a-time command sequencer with pre-emption retry.
module sdm_access_fsm
  import sdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       switch_req,
  input  logic       start_req,
  input  logic       mem_ready,
  input  logic       mem_ack,
  output acc_state_t state,
  output logic       mem_en,
  output logic       done
);

  acc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      AF_IDLE: begin
        if (switch_req)     nxt = AF_TURN;
        else if (start_req) nxt = AF_ISSUE;
      end
      AF_TURN:  nxt = AF_IDLE;
      AF_ISSUE: nxt = AF_CHECK;
      AF_CHECK: nxt = mem_ack ? AF_WAIT : AF_RETRY;
      AF_WAIT:  if (mem_ready) nxt = AF_IDLE;
      AF_RETRY: if (mem_ready) nxt = AF_ISSUE;
      default:  nxt = AF_IDLE;
    endcase
  end

  // completion of an acknowledged access
  assign done = (state == AF_WAIT) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= AF_IDLE;
      mem_en <= 1'b0;
    end else begin
      state  <= nxt;
      mem_en <= (nxt == AF_ISSUE);
    end
  end

endmodule

// File: rtl/sdm_mode_ctl.sv
// Chooses record / play / none, owns direction select and held length.
module sdm_mode_ctl
  import sdm_pkg::*;
#(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic          rec_req,
  input  logic          play_req,
  input  logic [AW-1:0] addr,
  output mode_t         mode,
  output logic          sel_rd,
  output logic          switch_now,
  output logic [AW-1:0] rec_len,
  output logic          rec_valid
);

  localparam logic [AW-1:0] ADDR_ZERO = '0;

  logic  cur_rec_nonempty;
  logic  rec_avail;
  mode_t want;

  assign cur_rec_nonempty = (mode == MD_REC) && (addr != ADDR_ZERO);
  assign rec_avail        = rec_valid || cur_rec_nonempty;

  always_comb begin
    if (rec_req)                     want = MD_REC;
    else if (play_req && rec_avail)  want = MD_PLAY;
    else                             want = MD_NONE;
  end

  // mode only moves between accesses
  assign switch_now = idle && (want != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MD_NONE;
      sel_rd    <= 1'b1;
      rec_len   <= '0;
      rec_valid <= 1'b0;
    end else if (switch_now) begin
      mode   <= want;
      sel_rd <= (want != MD_REC);
      if (cur_rec_nonempty) begin
        rec_len   <= addr;
        rec_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdm_addr_ctr.sv
// Word address counter with restart and optional wrap at a held length.
module sdm_addr_ctr #(
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic          wrap_en,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_inc;
  logic          at_last;

  assign addr_inc = addr + ONE;
  assign at_last  = (addr_inc == limit);

  always_ff @(posedge clk) begin
    if (rst || clear)               addr <= '0;
    else if (step && wrap_en && at_last) addr <= '0;
    else if (step)                  addr <= addr_inc;
  end

endmodule

// File: rtl/sdm_stream_master.sv
// Record/playback stream master for a refresh-pre-empting DRAM controller.
module sdm_stream_master
  import sdm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rec_req,
  input  logic          play_req,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          mem_en,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);

  acc_state_t    acc_state;
  mode_t         mode;
  logic          idle;
  logic          switch_now;
  logic          start_req;
  logic          acc_done;
  logic          take_sample;
  logic          rec_valid;
  logic [AW-1:0] rec_len;
  logic [AW-1:0] addr;

  assign idle = (acc_state == AF_IDLE);

  sdm_mode_ctl #(.AW(AW)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .idle       (idle),
    .rec_req    (rec_req),
    .play_req   (play_req),
    .addr       (addr),
    .mode       (mode),
    .sel_rd     (mem_rd),
    .switch_now (switch_now),
    .rec_len    (rec_len),
    .rec_valid  (rec_valid)
  );

  assign in_ready    = idle && !switch_now && mem_ready && (mode == MD_REC);
  assign take_sample = in_ready && in_valid;
  assign start_req   = mem_ready && !switch_now &&
                       (((mode == MD_REC) && in_valid) || (mode == MD_PLAY));

  sdm_access_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .switch_req (switch_now),
    .start_req  (start_req),
    .mem_ready  (mem_ready),
    .mem_ack    (mem_ack),
    .state      (acc_state),
    .mem_en     (mem_en),
    .done       (acc_done)
  );

  sdm_addr_ctr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clear   (switch_now),
    .step    (acc_done),
    .wrap_en (mode == MD_PLAY),
    .limit   (rec_len),
    .addr    (addr)
  );

  assign mem_addr = addr;

  // write data held across retries
  always_ff @(posedge clk) begin
    if (rst)              mem_wdata <= '0;
    else if (take_sample) mem_wdata <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= acc_done && (mode == MD_PLAY);
      if (acc_done && (mode == MD_PLAY)) out_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/sdm_stream_master_chk.sv
module sdm_stream_master_chk (
  input logic clk,
  input logic rst,
  input logic mem_en,
  input logic mem_rd,
  input logic mem_ready,
  input logic out_valid,
  input logic in_ready,
  input logic rec_valid
);

  // R1: reset leaves the command side quiet with read selected
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_en && mem_rd && !out_valid));

  // R2: a new issue follows an edge that saw ready high
  p_en_after_ready_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en) |-> $past(mem_ready));

  // R2: an issue is one cycle long
  p_en_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  // R3: direction settled a cycle before enable
  p_dir_settled_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en) |-> $stable(mem_rd));

  // R5: playback output is a single-cycle pulse
  p_out_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: no read command without a stored recording
  p_play_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_rd) |-> rec_valid);

  // R10: samples accepted only in write direction with memory ready
  p_inready_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (mem_ready && !mem_rd));

endmodule

bind sdm_stream_master sdm_stream_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_en    (mem_en),
  .mem_rd    (mem_rd),
  .mem_ready (mem_ready),
  .out_valid (out_valid),
  .in_ready  (in_ready),
  .rec_valid (rec_valid)
);

// File: tb/sim_sdm_stream_master.sv
module sim_sdm_stream_master;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int AW   = 22;
  localparam int MEMW = 64;
  localparam int ACC_BUSY = 3;
  localparam int REF_BUSY = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          rec_req, play_req, in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;
  logic          mem_en, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  sdm_stream_master #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data),
    .mem_en(mem_en), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int n_acc = 0;
  int n_pre = 0;
  int n_out = 0;
  int ref_req = 0;
  int ref_done = 0;
  int busy = 0;
  int exp_wa = 0;
  int exp_ra = 0;
  int len_b = 0;
  logic [DW-1:0] mem_arr [MEMW];
  logic [DW-1:0] sent_q[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] got_q[$];
  logic [AW-1:0] pre_addr;
  logic [DW-1:0] pre_data;
  bit   pre_open = 1'b0;
  logic en_prev = 1'b0, rd_prev = 1'b1, rdy_prev = 1'b1;

  assign mem_ready = (busy == 0);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // behavioural memory controller and per-clock command reference
  always @(posedge clk) begin
    if (rst) begin
      busy    <= 0;
      mem_ack <= 1'b0;
      en_prev <= 1'b0;
      rd_prev <= 1'b1;
      rdy_prev <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
      if (busy > 0) busy <= busy - 1;
      if (mem_en && !en_prev)
        check(rdy_prev, "R2", "enable without prior ready", rdy_prev, 1);
      if (mem_en)
        check(mem_ready, "R2", "enable while not ready", mem_ready, 1);
      if (mem_en && mem_ready) begin
        check(mem_rd == rd_prev, "R3", "direction moved at issue", mem_rd, rd_prev);
        if (ref_req != ref_done) begin
          n_pre++;
          pre_addr = mem_addr;
          pre_data = mem_wdata;
          pre_open = 1'b1;
        end else begin
          if (pre_open) begin
            check(mem_addr == pre_addr, "R4", "retry address", mem_addr, pre_addr);
            if (!mem_rd)
              check(mem_wdata == pre_data, "R4", "retry data", mem_wdata, pre_data);
            pre_open = 1'b0;
          end
          if (!mem_rd) begin
            check(mem_addr == AW'(exp_wa), "R6", "write address", mem_addr, exp_wa);
            if (sent_q.size() == 0)
              check(1'b0, "R10", "write with no sample", mem_wdata, 0);
            else begin
              check(mem_wdata == sent_q[0], "R10", "write data", mem_wdata, sent_q[0]);
              void'(sent_q.pop_front());
            end
            mem_arr[mem_addr[5:0]] = mem_wdata;
            exp_wa++;
          end else begin
            check(mem_addr == AW'(exp_ra), "R7", "read address", mem_addr, exp_ra);
            exp_q.push_back(mem_arr[mem_addr[5:0]]);
            mem_rdata <= mem_arr[mem_addr[5:0]];
            exp_ra = (exp_ra + 1 == len_b) ? 0 : exp_ra + 1;
          end
          busy    <= ACC_BUSY;
          mem_ack <= 1'b1;
          n_acc++;
        end
      end
      if (mem_ready && (ref_req != ref_done)) begin
        busy <= REF_BUSY;
        ref_done++;
      end
      en_prev  <= mem_en;
      rd_prev  <= mem_rd;
      rdy_prev <= mem_ready;
    end
  end

  // playback port compared away from the edge
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_out++;
      got_q.push_back(out_data);
      if (exp_q.size() == 0)
        check(1'b0, "R5", "unexpected out_valid", out_data, 0);
      else begin
        check(out_data == exp_q[0], "R5", "played sample", out_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic push(input logic [DW-1:0] v);
    sent_q.push_back(v);
    in_valid = 1'b1;
    in_data  = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic preempt_next();
    while (!mem_en) @(negedge clk);
    ref_req++;
  endtask

  task automatic wait_outs(input int n);
    int t = 0;
    while (n_out < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(n_out >= n, "R5", "playback output count", n_out, n);
  endtask

  task automatic start_rec();
    exp_wa = 0;
    rec_req = 1'b1;
  endtask

  task automatic stop_rec();
    settle();
    rec_req = 1'b0;
    if (exp_wa > 0) len_b = exp_wa;
    settle();
  endtask

  task automatic start_play();
    exp_ra = 0;
    n_out = 0;
    got_q.delete();
    play_req = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int pre0;
    rst = 1'b1; rec_req = 1'b0; play_req = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!mem_en, "R1", "mem_en in reset", mem_en, 0);
    check(mem_rd, "R1", "mem_rd in reset", mem_rd, 1);
    check(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    check(!in_ready, "R1", "in_ready in reset", in_ready, 0);
    check(mem_addr == '0, "R1", "mem_addr in reset", mem_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_en && mem_rd, "R1", "first cycle after reset", {mem_en, mem_rd}, 1);

    // R8: play before anything is recorded
    play_req = 1'b1;
    repeat (25) @(negedge clk);
    check(n_acc == 0, "R8", "commands issued with nothing recorded", n_acc, 0);
    check(n_out == 0, "R8", "outputs with nothing recorded", n_out, 0);
    play_req = 1'b0;
    @(negedge clk);

    // R6 R10: back-to-back record of five samples
    start_rec();
    for (int i = 0; i < 5; i++) push(16'hA000 + 16'(i));
    stop_rec();
    check(exp_wa == 5, "R6", "words written", exp_wa, 5);
    check(mem_arr[4] == 16'hA004, "R10", "last word stored", mem_arr[4], 16'hA004);

    // R5 R7: playback with several wraps
    start_play();
    wait_outs(12);
    check(got_q[0] == 16'hA000, "R6", "playback starts at zero", got_q[0], 16'hA000);
    check(got_q[5] == 16'hA000, "R7", "wrap after last word", got_q[5], 16'hA000);
    check(got_q[11] == 16'hA001, "R7", "second wrap", got_q[11], 16'hA001);

    // R4: refresh pre-empts a read
    pre0 = n_pre;
    preempt_next();
    wait_outs(18);
    check(n_pre == pre0 + 1, "R4", "read pre-emptions seen", n_pre, pre0 + 1);
    play_req = 1'b0;
    settle();
    check(exp_q.size() == 0, "R5", "reads left undelivered", exp_q.size(), 0);

    // R11: both requests high, record wins; R4 on a write; spaced samples
    play_req = 1'b1;
    start_rec();
    fork
      preempt_next();
    join_none
    for (int i = 0; i < 3; i++) begin
      push(16'hB100 + 16'(i));
      repeat (i + 2) @(negedge clk);
    end
    settle();
    check(n_pre == pre0 + 2, "R4", "write pre-emptions seen", n_pre, pre0 + 2);
    check(exp_wa == 3, "R11", "record won over play", exp_wa, 3);
    play_req = 1'b0;
    stop_rec();
    check(mem_arr[2] == 16'hB102, "R10", "spaced sample stored", mem_arr[2], 16'hB102);

    // R9: a recording that captures nothing keeps the old length
    start_rec();
    repeat (6) @(negedge clk);
    stop_rec();
    start_play();
    wait_outs(7);
    check(got_q[2] == 16'hB102, "R9", "last word of held recording", got_q[2], 16'hB102);
    check(got_q[3] == 16'hB100, "R9", "wrap at held length 3", got_q[3], 16'hB100);
    play_req = 1'b0;
    settle();
    check(sent_q.size() == 0, "R10", "samples not written", sent_q.size(), 0);

    finish_run();
  end

endmodule